// File: doc/BRIEF.md
# Synchronous DRAM Command Front End with Bank Tracking

This block is the device-side front end of a four-bank synchronous DRAM. On every rising clock edge it samples the clock-enable, chip-select and the three active-low command strobes. It also samples the bank select, the address bus and the data-mask lanes, and it turns them into one command event per edge. It keeps the open or closed state of each bank and the row held open in it. It counts out read and write bursts, closes a bank on its own when a burst asked for auto-precharge, and gates the data lanes with the mask at the latency each direction needs.

The outputs serve the array and I/O logic around it. A registered event code tells what was accepted at the last edge. Per-bank open flags and rows are visible, and per-lane read output enables and write strobes mark each data beat. Misuse by the controller, such as touching a closed bank or activating an open one, sets a sticky error flag, and the offending command has no other effect.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset all banks are closed, protoErr is 0, evtCode is 0 (no-op), readOe and writeStrobe are 0 and the burst length is 1.
- R2: With chipSelN low, {rowStrobeN,colStrobeN,writeEnN} selects the command: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode set. The accepted command shows on evtCode one edge later: 0 none, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 refresh, 7 mode set. Read and write also load colAddr from addr[COL_W-1:0].
- R3: With chipSelN high the edge carries no command, and a burst already running keeps producing beats.
- R4: Activate to a closed bank opens it and stores addr as its row. Activate to an open bank sets protoErr and changes nothing else.
- R5: Read or write to a closed bank, or to any bank while a burst with auto-precharge still has beats left, sets protoErr and is otherwise ignored.
- R6: Precharge with addr[10] high closes every bank whatever bankSel holds. With addr[10] low it closes only the bank bankSel selects.
- R7: Read or write with addr[10] high closes its bank at the edge of the burst's last beat. With addr[10] low the bank stays open.
- R8: Mode set takes the burst length from addr[2:0]: codes 0, 1 and 2 give 1, 2 and 4 beats, and codes 3 to 7 give 8. Refresh and mode set are accepted only when all banks are closed, and are otherwise ignored with no error.
- R9: An accepted read or write makes a beat at its own edge and at each of the next burst-length-minus-one active edges. A new accepted read or write replaces a running burst.
- R10: A write beat at an edge drives writeStrobe to the inverse of dataMask sampled at that same edge.
- R11: A read beat at an edge drives readOe to the inverse of dataMask sampled two active edges earlier.
- R12: An edge with clkEn low changes no register or output.
- R13: protoErr stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock enable; low freezes all state |
| chipSelN | input | 1 | Active-low command enable |
| rowStrobeN | input | 1 | Active-low row strobe, command bit 2 |
| colStrobeN | input | 1 | Active-low column strobe, command bit 1 |
| writeEnN | input | 1 | Active-low write enable, command bit 0 |
| bankSel | input | 2 | Bank select |
| addr | input | ROW_W | Row, column, auto-precharge and mode field |
| dataMask | input | MASK_W | Per-lane data mask, high masks |
| bankOpen | output | 4 | Open flag per bank |
| openRows | output | 4 x ROW_W | Open row per bank, valid while open |
| evtCode | output | 3 | Command accepted at the last active edge |
| evtBank | output | 2 | Bank of the last accepted command |
| colAddr | output | COL_W | Column of the last accepted read or write |
| readOe | output | MASK_W | Per-lane read output enable for the current beat |
| writeStrobe | output | MASK_W | Per-lane write strobe for the current beat |
| protoErr | output | 1 | Sticky protocol error flag |

## Verification
The hardest state to reach is a burst with auto-precharge pending that meets other traffic: a deselected edge, a clock-enable freeze, a second read to the same bank, and mask changes that only reach the read enables two edges later. Random traffic rarely lines these up, so directed sequences set a four-beat burst length and then place each of these events on chosen beats. After that, long weighted-random runs with periodic resets compare every output against a bench reference model at every edge.

// File: rtl/sdram_front_pkg.sv
package sdram_front_pkg;
  localparam int BANK_W = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  localparam logic [2:0] CMD_NOP     = 3'b111;
  localparam logic [2:0] CMD_ACT     = 3'b011;
  localparam logic [2:0] CMD_READ    = 3'b101;
  localparam logic [2:0] CMD_WRITE   = 3'b100;
  localparam logic [2:0] CMD_PRE     = 3'b010;
  localparam logic [2:0] CMD_REFRESH = 3'b001;
  localparam logic [2:0] CMD_MODESET = 3'b000;

  typedef enum logic [2:0] {
    EV_NOP = 3'd0, EV_ACT = 3'd1, EV_READ = 3'd2, EV_WRITE = 3'd3,
    EV_PRE = 3'd4, EV_PREALL = 3'd5, EV_REFRESH = 3'd6, EV_MODESET = 3'd7
  } evt_e;

  typedef struct packed {
    logic              tick;
    logic              doAct;
    logic              doPreOne;
    logic              doPreAll;
    logic              doApClose;
    logic [BANK_W-1:0] apBank;
    logic              readBeat;
    logic              writeBeat;
    logic              setErr;
    evt_e              evt;
  } strobe_t;
endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_front_pkg::*;
#(
  parameter int MAX_BL_LOG = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 apFlag,
  input  logic [2:0]           modeField,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              stb
);
  localparam int CNT_W = (MAX_BL_LOG > 0) ? MAX_BL_LOG : 1;
  localparam int LOG_W = $clog2(MAX_BL_LOG + 1);

  logic [CNT_W-1:0]  burstLeft;
  logic [LOG_W-1:0]  blLog;
  logic              burstAp;
  logic              burstRd;
  logic [BANK_W-1:0] burstBank;

  logic [2:0]       cmdBits;
  logic             isAct, isRd, isWr, isPre, isRef, isMrs;
  logic             tgtOpen, allIdle, apBusy, contBeat;
  logic             rwOk, actOk, refOk, mrsOk, lastBeat;
  logic [CNT_W-1:0] blMinus1;
  evt_e             evtNext;

  always_comb begin
    cmdBits  = csN ? CMD_NOP : {rasN, casN, weN};
    isAct    = (cmdBits == CMD_ACT);
    isRd     = (cmdBits == CMD_READ);
    isWr     = (cmdBits == CMD_WRITE);
    isPre    = (cmdBits == CMD_PRE);
    isRef    = (cmdBits == CMD_REFRESH);
    isMrs    = (cmdBits == CMD_MODESET);
    tgtOpen  = bankOpen[bankSel];
    allIdle  = (bankOpen == '0);
    contBeat = (burstLeft != '0);
    apBusy   = contBeat && burstAp;
    rwOk     = (isRd || isWr) && tgtOpen && !apBusy;
    actOk    = isAct && !tgtOpen;
    refOk    = isRef && allIdle;
    mrsOk    = isMrs && allIdle;
    blMinus1 = CNT_W'((1 << blLog) - 1);
    lastBeat = rwOk ? (blLog == '0) : (burstLeft == CNT_W'(1));

    evtNext = EV_NOP;
    if (actOk)                 evtNext = EV_ACT;
    else if (rwOk && isRd)     evtNext = EV_READ;
    else if (rwOk)             evtNext = EV_WRITE;
    else if (isPre && apFlag)  evtNext = EV_PREALL;
    else if (isPre)            evtNext = EV_PRE;
    else if (refOk)            evtNext = EV_REFRESH;
    else if (mrsOk)            evtNext = EV_MODESET;

    stb.tick      = clkEn;
    stb.doAct     = actOk;
    stb.doPreOne  = isPre && !apFlag;
    stb.doPreAll  = isPre && apFlag;
    stb.doApClose = lastBeat && (rwOk ? apFlag : burstAp) && (rwOk || contBeat);
    stb.apBank    = rwOk ? bankSel : burstBank;
    stb.readBeat  = rwOk ? isRd : (contBeat && burstRd);
    stb.writeBeat = rwOk ? isWr : (contBeat && !burstRd);
    stb.setErr    = ((isRd || isWr) && !rwOk) || (isAct && tgtOpen);
    stb.evt       = evtNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLeft <= '0;
      blLog     <= '0;
      burstAp   <= 1'b0;
      burstRd   <= 1'b0;
      burstBank <= '0;
    end else if (clkEn) begin
      if (rwOk) begin
        burstLeft <= blMinus1;
        burstAp   <= apFlag;
        burstRd   <= isRd;
        burstBank <= bankSel;
      end else if (contBeat) begin
        burstLeft <= burstLeft - 1'b1;
      end
      if (mrsOk) begin
        blLog <= (modeField > 3'(MAX_BL_LOG)) ? LOG_W'(MAX_BL_LOG) : modeField[LOG_W-1:0];
      end
    end
  end

  AST_BURST_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && contBeat && !rwOk) |=> (burstLeft == $past(burstLeft) - 1'b1)); // R9
  AST_MODESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evt == EV_MODESET) |-> (bankOpen == '0)); // R8
endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_front_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int MASK_W = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  input  logic [BANK_W-1:0]               bankSel,
  input  logic [ROW_W-1:0]                addr,
  input  logic [MASK_W-1:0]               dataMask,
  output logic [NUM_BANKS-1:0]            bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] openRows,
  output logic [2:0]                      evtCode,
  output logic [BANK_W-1:0]               evtBank,
  output logic [COL_W-1:0]                colAddr,
  output logic [MASK_W-1:0]               readOe,
  output logic [MASK_W-1:0]               writeStrobe,
  output logic                            protoErr
);
  logic [MASK_W-1:0] maskD1, maskD2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             isOpen;
    logic [ROW_W-1:0] rowQ;
    logic             hitSel, closeNow;
    assign hitSel   = (bankSel == BANK_W'(b));
    assign closeNow = stb.doPreAll || (stb.doPreOne && hitSel) ||
                      (stb.doApClose && (stb.apBank == BANK_W'(b)));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        isOpen <= 1'b0;
        rowQ   <= '0;
      end else if (stb.tick) begin
        if (stb.doAct && hitSel) begin
          isOpen <= 1'b1;
          rowQ   <= addr;
        end else if (closeNow) begin
          isOpen <= 1'b0;
        end
      end
    end
    assign bankOpen[b] = isOpen;
    assign openRows[b] = rowQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskD1      <= '0;
      maskD2      <= '0;
      readOe      <= '0;
      writeStrobe <= '0;
      evtCode     <= 3'(EV_NOP);
      evtBank     <= '0;
      colAddr     <= '0;
      protoErr    <= 1'b0;
    end else if (stb.tick) begin
      maskD1      <= dataMask;
      maskD2      <= maskD1;
      readOe      <= {MASK_W{stb.readBeat}} & ~maskD2;
      writeStrobe <= {MASK_W{stb.writeBeat}} & ~dataMask;
      evtCode     <= 3'(stb.evt);
      if (stb.evt != EV_NOP) evtBank <= bankSel;
      if (stb.evt == EV_READ || stb.evt == EV_WRITE) colAddr <= addr[COL_W-1:0];
      protoErr    <= protoErr | stb.setErr;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R13
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (evtCode == 3'(EV_ACT)) |-> bankOpen[evtBank]); // R4
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (evtCode == 3'(EV_PREALL)) |-> (bankOpen == '0)); // R6
  AST_BEAT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !((|readOe) && (|writeStrobe))); // R9
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> ($stable(bankOpen) && $stable(readOe) && $stable(protoErr))); // R12
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_front_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 8,
  parameter int MASK_W     = 2,
  parameter int AP_BIT     = 10,
  parameter int MAX_BL_LOG = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            clkEn,
  input  logic                            chipSelN,
  input  logic                            rowStrobeN,
  input  logic                            colStrobeN,
  input  logic                            writeEnN,
  input  logic [1:0]                      bankSel,
  input  logic [ROW_W-1:0]                addr,
  input  logic [MASK_W-1:0]               dataMask,
  output logic [3:0]                      bankOpen,
  output logic [3:0][ROW_W-1:0]           openRows,
  output logic [2:0]                      evtCode,
  output logic [1:0]                      evtBank,
  output logic [COL_W-1:0]                colAddr,
  output logic [MASK_W-1:0]               readOe,
  output logic [MASK_W-1:0]               writeStrobe,
  output logic                            protoErr
);
  strobe_t stb;

  sdram_cmd_ctrl #(.MAX_BL_LOG(MAX_BL_LOG)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .csN(chipSelN),
    .rasN(rowStrobeN), .casN(colStrobeN), .weN(writeEnN),
    .bankSel(bankSel), .apFlag(addr[AP_BIT]), .modeField(addr[2:0]),
    .bankOpen(bankOpen), .stb(stb)
  );

  sdram_bank_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .MASK_W(MASK_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bankSel(bankSel), .addr(addr),
    .dataMask(dataMask), .bankOpen(bankOpen), .openRows(openRows),
    .evtCode(evtCode), .evtBank(evtBank), .colAddr(colAddr),
    .readOe(readOe), .writeStrobe(writeStrobe), .protoErr(protoErr)
  );
endmodule

// File: tb/sdram_cmd_front_tb.sv
`timescale 1ns/1ps
module sdram_cmd_front_tb_top;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  logic clk = 1'b0;
  logic rstN = 1'b0, clkEn = 1'b1, chipSelN = 1'b1;
  logic rowStrobeN = 1'b1, colStrobeN = 1'b1, writeEnN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [11:0] addr = '0;
  logic [1:0] dataMask = '0;
  logic [3:0] bankOpen;
  logic [3:0][11:0] openRows;
  logic [2:0] evtCode;
  logic [1:0] evtBank;
  logic [7:0] colAddr;
  logic [1:0] readOe, writeStrobe;
  logic protoErr;

  always #10 clk = ~clk;

  sdram_cmd_front dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSelN(chipSelN),
    .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN), .writeEnN(writeEnN),
    .bankSel(bankSel), .addr(addr), .dataMask(dataMask),
    .bankOpen(bankOpen), .openRows(openRows), .evtCode(evtCode), .evtBank(evtBank),
    .colAddr(colAddr), .readOe(readOe), .writeStrobe(writeStrobe), .protoErr(protoErr)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // reference model state
  logic [3:0] mOpen;
  logic [3:0][11:0] mRow;
  logic mErr, mAp, mRd;
  logic [2:0] mEvt;
  logic [1:0] mEvtBank, mBank, mM1, mM2, mOe, mWs;
  logic [7:0] mCol;
  int mBl, mLeft;

  function automatic int blFromCode(input logic [2:0] code);
    return (code >= 3) ? 8 : (1 << code);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mOpen = '0; mRow = '0; mErr = 0; mAp = 0; mRd = 0; mEvt = 0; mEvtBank = 0;
    mBank = 0; mM1 = 0; mM2 = 0; mOe = 0; mWs = 0; mCol = 0; mBl = 1; mLeft = 0;
  endtask

  task automatic compareAll();
    check("R4 R6 R7 bank open flags", 64'(bankOpen), 64'(mOpen));
    for (int b = 0; b < 4; b++)
      if (mOpen[b]) check("R4 open row", 64'(openRows[b]), 64'(mRow[b]));
    check("R2 event code", 64'(evtCode), 64'(mEvt));
    check("R2 event bank", 64'(evtBank), 64'(mEvtBank));
    check("R2 column", 64'(colAddr), 64'(mCol));
    check("R11 read enable", 64'(readOe), 64'(mOe));
    check("R10 write strobe", 64'(writeStrobe), 64'(mWs));
    check("R13 error flag", 64'(protoErr), 64'(mErr));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; clkEn = 1; chipSelN = 1; {rowStrobeN, colStrobeN, writeEnN} = C_NOP;
    bankSel = 0; addr = 0; dataMask = 0;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic step(input logic cke, input logic cs, input logic [2:0] cmd,
                      input logic [1:0] ba, input logic [11:0] a, input logic [1:0] dm);
    logic [2:0] c, ev;
    logic tgt, apB, isRw, rwOk, rb, wb, last, apc;
    logic [1:0] apBank;
    logic [3:0] nOpen;
    @(negedge clk);
    clkEn = cke; chipSelN = cs; {rowStrobeN, colStrobeN, writeEnN} = cmd;
    bankSel = ba; addr = a; dataMask = dm;
    if (cke) begin
      c = cs ? C_NOP : cmd;
      tgt = mOpen[ba];
      apB = (mLeft != 0) && mAp;
      isRw = (c == C_RD) || (c == C_WR);
      rwOk = isRw && tgt && !apB;
      if (isRw && !rwOk) mErr = 1;
      if (c == C_ACT && tgt) mErr = 1;
      rb = rwOk ? (c == C_RD) : ((mLeft != 0) && mRd);
      wb = rwOk ? (c == C_WR) : ((mLeft != 0) && !mRd);
      last = rwOk ? (mBl == 1) : (mLeft == 1);
      apc = last && (rwOk ? a[10] : mAp);
      apBank = rwOk ? ba : mBank;
      nOpen = mOpen;
      ev = 0;
      if (apc) nOpen[apBank] = 0;
      case (c)
        C_ACT: if (!tgt) begin nOpen[ba] = 1; mRow[ba] = a; ev = 1; end
        C_RD, C_WR: if (rwOk) begin ev = (c == C_RD) ? 3'd2 : 3'd3; mCol = a[7:0]; end
        C_PRE: if (a[10]) begin nOpen = '0; ev = 5; end else begin nOpen[ba] = 0; ev = 4; end
        C_REF: if (mOpen == 0) ev = 6;
        C_MRS: if (mOpen == 0) begin ev = 7; end
        default: ;
      endcase
      if (rwOk) begin
        mLeft = mBl - 1; mAp = a[10]; mRd = (c == C_RD); mBank = ba;
      end else if (mLeft != 0) begin
        mLeft = mLeft - 1;
      end
      if (ev == 7) mBl = blFromCode(a[2:0]);
      mOe = {2{rb}} & ~mM2;
      mWs = {2{wb}} & ~dm;
      mM2 = mM1; mM1 = dm;
      mEvt = ev;
      if (ev != 0) mEvtBank = ba;
      mOpen = nOpen;
    end
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic cmdStep(input logic [2:0] cmd, input logic [1:0] ba, input logic [11:0] a,
                         input logic [1:0] dm);
    step(1'b1, 1'b0, cmd, ba, a, dm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5eed_0042);
    modelReset();
    doReset();
    // R1: reset state
    check("R1 banks closed", 64'(bankOpen), 64'h0);
    check("R1 error clear", 64'(protoErr), 64'h0);
    check("R1 event none", 64'(evtCode), 64'h0);
    check("R1 read enable low", 64'(readOe), 64'h0);
    check("R1 write strobe low", 64'(writeStrobe), 64'h0);

    // R2 R8: mode set to burst of four while idle
    cmdStep(C_MRS, 2'd0, 12'h002, 2'b00);
    check("R8 mode set accepted", 64'(evtCode), 64'd7);
    // R4: activate opens the bank with its row
    cmdStep(C_ACT, 2'd0, 12'h123, 2'b00);
    check("R4 activate opens bank 0", 64'(bankOpen), 64'h1);
    check("R4 row stored", 64'(openRows[0]), 64'h123);
    // R8: refresh while a bank is open is ignored without error
    cmdStep(C_REF, 2'd1, 12'h000, 2'b00);
    check("R8 refresh ignored when open", 64'(evtCode), 64'd0);
    check("R8 no error on ignored refresh", 64'(protoErr), 64'd0);
    // R4: activate an open bank
    cmdStep(C_ACT, 2'd0, 12'h456, 2'b00);
    check("R4 second activate flags error", 64'(protoErr), 64'd1);
    check("R4 row unchanged", 64'(openRows[0]), 64'h123);

    // R5 R7 R3 R11 R9: four-beat read with auto-precharge
    doReset();
    cmdStep(C_MRS, 2'd0, 12'h002, 2'b00);
    cmdStep(C_ACT, 2'd1, 12'h055, 2'b00);
    cmdStep(C_RD, 2'd1, 12'h405, 2'b00);
    check("R11 first beat enabled", 64'(readOe), 64'h3);
    check("R2 read column", 64'(colAddr), 64'h05);
    step(1'b1, 1'b1, C_ACT, 2'd1, 12'h000, 2'b11);
    check("R3 deselected edge keeps burst", 64'(readOe), 64'h3);
    check("R3 deselected edge no event", 64'(evtCode), 64'd0);
    cmdStep(C_RD, 2'd1, 12'h000, 2'b00);
    check("R5 read during auto-precharge burst", 64'(protoErr), 64'd1);
    check("R7 bank still open mid-burst", 64'(bankOpen), 64'h2);
    cmdStep(C_NOP, 2'd0, 12'h000, 2'b00);
    check("R11 mask from two edges earlier", 64'(readOe), 64'h0);
    check("R7 closed at last beat", 64'(bankOpen), 64'h0);
    cmdStep(C_NOP, 2'd0, 12'h000, 2'b00);
    check("R9 burst over", 64'(readOe), 64'h0);

    // R5 R12 R6 R10
    doReset();
    cmdStep(C_WR, 2'd2, 12'h001, 2'b00);
    check("R5 write to closed bank", 64'(protoErr), 64'd1);
    check("R5 write to closed bank no strobe", 64'(writeStrobe), 64'h0);
    doReset();
    cmdStep(C_ACT, 2'd3, 12'h007, 2'b00);
    step(1'b0, 1'b0, C_PRE, 2'd0, 12'h400, 2'b00);
    check("R12 suspended edge keeps bank", 64'(bankOpen), 64'h8);
    check("R12 suspended edge keeps event", 64'(evtCode), 64'd1);
    cmdStep(C_ACT, 2'd2, 12'h0aa, 2'b00);
    cmdStep(C_PRE, 2'd3, 12'h000, 2'b00);
    check("R6 single precharge", 64'(bankOpen), 64'h4);
    cmdStep(C_ACT, 2'd0, 12'h0bb, 2'b00);
    cmdStep(C_WR, 2'd0, 12'h000, 2'b01);
    check("R10 write mask same edge", 64'(writeStrobe), 64'h2);
    cmdStep(C_PRE, 2'd1, 12'h400, 2'b00);
    check("R6 precharge all", 64'(bankOpen), 64'h0);
    check("R6 precharge all event", 64'(evtCode), 64'd5);
    check("R13 error stays clear", 64'(protoErr), 64'd0);

    // weighted random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] cmd;
      if (i % 250 == 0) doReset();
      r = $urandom % 12;
      case (r)
        0, 1, 2: cmd = C_ACT;
        3, 4:    cmd = C_RD;
        5, 6:    cmd = C_WR;
        7, 8:    cmd = C_PRE;
        9:       cmd = C_NOP;
        10:      cmd = C_REF;
        default: cmd = C_MRS;
      endcase
      step(($urandom % 16) != 0, ($urandom % 8) == 0, cmd, 2'($urandom), 12'($urandom),
           2'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule